// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block is the target end of a two-wire management link. It serves a host that runs the management clock and drives the serial data line. The block oversamples the management clock with its own system clock and acts once for each rising edge it detects. On each such edge it shifts in one serial bit. A bit counts as a one only while the host is actually driving the line high.

A run of 32 consecutive ones synchronises the block to a frame. The next sixteen bits form a header that gives the start code, the operation and the register address, followed by two turnaround bits. A read header makes the block return the addressed 16-bit register serially, most significant bit first. A write header makes it store the sixteen data bits that follow the turnaround. The register file has 32 entries and comes out of reset with an identifier pair in entries 2 and 3. Any PHY address is answered.

Top module: `mdio_target`

## Requirements
- R1: The block acts only on a rising management-clock edge, which it detects by comparing `mgmt_clk` with the level seen on the previous system clock. It never changes `resp_data` or a register in any other cycle.
- R2: The bit shifted in on an edge is `host_data` AND `host_oe`. A high data bit sent while `host_oe` is low is taken as 0.
- R3: A frame is recognised only after 32 consecutive ones. With only 31 ones before the frame, the block gives no response.
- R4: The sixteen bits after the preamble are decoded MSB first. Bits 15:14 are the start code and must be 01. Bits 13:12 are the operation: 01 means write and 10 means read. Bits 6:2 are the register address. Bits 1:0 are the turnaround.
- R5: A write is accepted only when the turnaround is 10. Its sixteen data bits, MSB first, replace the addressed register on the last data edge. With any other turnaround the register is left unchanged.
- R6: A read is accepted when turnaround bit 0 is 0, so both 00 (host released) and 10 are valid. The register is returned MSB first on the sixteen edges that follow the turnaround.
- R7: A bad start code or an unknown operation produces no response and no write. `resp_data` keeps its value.
- R8: `resp_data` is registered. It holds between edges and after a frame ends.
- R9: Synchronous reset sets `resp_data` to 0. It clears every register except entry 2, which becomes 0x0022, and entry 3, which becomes 0x161A.
- R10: The PHY address field (bits 11:7 of the header) is ignored, so every address is answered.
- R11: A new run of 32 ones restarts frame decoding, even when it arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the management clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_clk | input | 1 | Management clock from the host, synchronous to `clk` |
| host_data | input | 1 | Serial data bit driven by the host |
| host_oe | input | 1 | High while the host drives the data line |
| resp_data | output | 1 | Serial bit returned during a read |

## Verification
The assertions assume that `mgmt_clk` is already synchronous to `clk` and stays at each level for at least one system clock. They also assume the host releases the line (`host_oe` low) whenever the block is returning read data. The stimulus holds every management-clock phase for two system clocks and changes inputs only on falling system-clock edges. Every read frame releases the line for its turnaround or data bits, except for the case that deliberately drives turnaround 10.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

    typedef enum logic [1:0] {
        MT_IDLE  = 2'd0,
        MT_READ  = 2'd1,
        MT_WRITE = 2'd2
    } mt_state_e;

    localparam logic [1:0] MT_START_CODE = 2'b01;
    localparam logic [1:0] MT_OP_WRITE   = 2'b01;
    localparam logic [1:0] MT_OP_READ    = 2'b10;
    localparam logic [1:0] MT_TA_WRITE   = 2'b10;

endpackage

// File: rtl/mdio_target_front.sv
module mdio_target_front #(
    parameter int SHIFT_W = 32,
    parameter int OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mgmt_clk,
    input  logic             host_data,
    input  logic             host_oe,
    output logic             edge_o,
    output logic             sync_o,
    output logic [OUT_W-1:0] win_o
);

    typedef struct packed {
        logic               prev;
        logic [SHIFT_W-1:0] sh;
    } front_s;

    front_s front_d, front_q;
    logic [SHIFT_W-1:0] shifted;

    always_comb begin
        front_d      = front_q;
        front_d.prev = mgmt_clk;
        edge_o       = mgmt_clk & ~front_q.prev;
        shifted      = {front_q.sh[SHIFT_W-2:0], host_data & host_oe};
        if (edge_o) begin
            front_d.sh = shifted;
        end
        sync_o = &shifted;
        win_o  = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

endmodule

// File: rtl/mdio_target_ctrl.sv
module mdio_target_ctrl
    import mdio_target_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 5,
    parameter int CNT_W = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_i,
    input  logic          sync_i,
    input  logic [DW-1:0] win_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          resp_o
);

    localparam int REG_LSB   = 2;
    localparam int OP_LSB    = DW - 4;
    localparam int START_LSB = DW - 2;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(2 * DW);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(DW);

    typedef struct packed {
        mt_state_e        st;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dout;
        logic             resp;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    logic [CNT_W-1:0] cnt_w;
    logic             arm_w;
    mt_state_e        st_w;
    logic [DW-1:0]    dsh_w;
    logic             start_ok, is_wr, is_rd;

    always_comb begin
        ctrl_d    = ctrl_q;
        cnt_w     = ctrl_q.cnt;
        arm_w     = ctrl_q.armed;
        st_w      = ctrl_q.st;
        dsh_w     = ctrl_q.dout;
        rd_addr_o = win_i[REG_LSB +: AW];
        wr_en_o   = 1'b0;
        wr_addr_o = ctrl_q.addr;
        wr_data_o = win_i;
        start_ok  = win_i[START_LSB +: 2] == MT_START_CODE;
        is_wr     = start_ok && win_i[OP_LSB +: 2] == MT_OP_WRITE
                    && win_i[1:0] == MT_TA_WRITE;
        is_rd     = start_ok && win_i[OP_LSB +: 2] == MT_OP_READ && !win_i[0];

        if (edge_i) begin
            if (sync_i) begin
                cnt_w = CNT_LOAD;
                arm_w = 1'b1;
            end
            // header fully shifted in: classify the frame
            if (arm_w && cnt_w == CNT_HDR) begin
                st_w = is_wr ? MT_WRITE : (is_rd ? MT_READ : MT_IDLE);
                if (st_w != MT_IDLE) begin
                    ctrl_d.addr = rd_addr_o;
                end
                if (st_w == MT_READ) begin
                    dsh_w = rd_data_i;
                end
            end
            // data phase of a read: one bit out per edge, MSB first
            if (arm_w && cnt_w < CNT_HDR && st_w == MT_READ) begin
                ctrl_d.resp = dsh_w[DW-1];
                dsh_w       = {dsh_w[DW-2:0], 1'b0};
            end
            // last data edge: commit a write and go idle
            if (arm_w && cnt_w == '0 && st_w != MT_IDLE) begin
                wr_en_o = st_w == MT_WRITE;
                st_w    = MT_IDLE;
            end
            if (arm_w) begin
                if (cnt_w == '0) begin
                    arm_w = 1'b0;
                end else begin
                    cnt_w = cnt_w - 1'b1;
                end
            end
            ctrl_d.cnt   = cnt_w;
            ctrl_d.armed = arm_w;
            ctrl_d.st    = st_w;
            ctrl_d.dout  = dsh_w;
        end
        resp_o = ctrl_q.resp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{st: MT_IDLE, armed: 1'b0, cnt: '0, addr: '0, dout: '0, resp: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/mdio_target_regs.sv
module mdio_target_regs #(
    parameter int              DW     = 16,
    parameter int              AW     = 5,
    parameter int              ID_IDX = 2,
    parameter logic [DW-1:0]   ID_HI  = 16'h0022,
    parameter logic [DW-1:0]   ID_LO  = 16'h161A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int NREG = 2 ** AW;

    logic [DW-1:0] ent_view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        localparam logic [DW-1:0] RST_VAL = (i == ID_IDX)     ? ID_HI :
                                            (i == ID_IDX + 1) ? ID_LO : '0;
        logic [DW-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_addr == AW'(i)) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= RST_VAL;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_view[i] = ent_q;
    end

    assign rd_data = ent_view[rd_addr];

endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
    parameter int                  DATA_W = 16,
    parameter int                  REG_AW = 5,
    parameter logic [DATA_W-1:0]   ID_HI  = 16'h0022,
    parameter logic [DATA_W-1:0]   ID_LO  = 16'h161A
) (
    input  logic clk,
    input  logic rst,
    input  logic mgmt_clk,
    input  logic host_data,
    input  logic host_oe,
    output logic resp_data
);

    localparam int SHIFT_W = 2 * DATA_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);

    logic              edge_w, sync_w, wr_en;
    logic [DATA_W-1:0] win_w, rd_data_w, wr_data_w;
    logic [REG_AW-1:0] rd_addr_w, wr_addr_w;

    mdio_target_front #(.SHIFT_W(SHIFT_W), .OUT_W(DATA_W)) u_front (
        .clk(clk), .rst(rst), .mgmt_clk(mgmt_clk), .host_data(host_data),
        .host_oe(host_oe), .edge_o(edge_w), .sync_o(sync_w), .win_o(win_w)
    );

    mdio_target_ctrl #(.DW(DATA_W), .AW(REG_AW), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .edge_i(edge_w), .sync_i(sync_w), .win_i(win_w),
        .rd_data_i(rd_data_w), .rd_addr_o(rd_addr_w), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr_w), .wr_data_o(wr_data_w), .resp_o(resp_data)
    );

    mdio_target_regs #(.DW(DATA_W), .AW(REG_AW), .ID_IDX(2), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr_w),
        .wr_data(wr_data_w), .rd_addr(rd_addr_w), .rd_data(rd_data_w)
    );

endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk #(
    parameter int LOAD = 32
) (
    input logic clk,
    input logic rst,
    input logic mgmt_clk,
    input logic host_data,
    input logic host_oe,
    input logic resp_data,
    input logic wr_en
);

    localparam int RUN_W = $clog2(LOAD + 1);

    logic             mc_prev, seen_sync;
    logic [RUN_W-1:0] ones_run;
    logic             rise;

    assign rise = mgmt_clk & ~mc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_prev   <= 1'b0;
            ones_run  <= '0;
            seen_sync <= 1'b0;
        end else begin
            mc_prev <= mgmt_clk;
            if (rise) begin
                if (host_data && host_oe) begin
                    if (ones_run != RUN_W'(LOAD)) ones_run <= ones_run + 1'b1;
                    if (ones_run >= RUN_W'(LOAD - 1)) seen_sync <= 1'b1;
                end else begin
                    ones_run <= '0;
                end
            end
        end
    end

    // R1 / R8: output moves only after a detected management-clock rise
    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(resp_data));

    // R1: register file is written only on a rising edge
    p_wr_edge_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rise);

    // R3: no write before a full run of ones has been seen
    p_wr_sync_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> seen_sync);

    // R6: with the host driving the line, the block does not return data
    p_resp_release_r6: assert property (@(posedge clk) disable iff (rst)
        (rise && host_oe) |=> $stable(resp_data));

endmodule

bind mdio_target mdio_target_chk #(.LOAD(SHIFT_W)) u_chk (
    .clk(clk), .rst(rst), .mgmt_clk(mgmt_clk), .host_data(host_data),
    .host_oe(host_oe), .resp_data(resp_data), .wr_en(wr_en)
);

// File: tb/mdio_target_bench.sv
module mdio_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mgmt_clk = 1'b0;
    logic host_data = 1'b0;
    logic host_oe = 1'b0;
    logic resp_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_target u_mdio_target (
        .clk(clk), .rst(rst), .mgmt_clk(mgmt_clk), .host_data(host_data),
        .host_oe(host_oe), .resp_data(resp_data)
    );

    // behavioural reference: integer counter that runs negative, array of registers
    int          m_cnt = 0;
    logic [31:0] m_data = '0;
    int          m_st = 0;
    int          m_reg = 0;
    logic [15:0] m_out = '0;
    logic        m_resp = 1'b0;
    logic [15:0] m_regs [32];

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        m_regs[2] = 16'h0022;
        m_regs[3] = 16'h161A;
    endfunction

    function automatic void model_edge(bit d, bit oe);
        int start, op, ta;
        m_data = {m_data[30:0], d & oe};
        if (m_data == 32'hFFFF_FFFF) m_cnt = 32;
        if (m_cnt == 16) begin
            start = int'(m_data[15:14]);
            op    = int'(m_data[13:12]);
            ta    = int'(m_data[1:0]);
            if (start == 1 && op == 1 && ta == 2) m_st = 2;
            else if (start == 1 && op == 2 && (ta % 2) == 0) m_st = 1;
            else m_st = 0;
            if (m_st != 0) m_reg = int'(m_data[6:2]);
            if (m_st == 1) m_out = m_regs[m_reg];
        end
        if (m_cnt < 16 && m_st == 1) begin
            m_resp = m_out[15];
            m_out  = m_out << 1;
        end
        if (m_cnt == 0 && m_st != 0) begin
            if (m_st == 2) m_regs[m_reg] = m_data[15:0];
            m_st = 0;
        end
        m_cnt--;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sys_step();
        @(negedge clk);
        check(resp_data === m_resp, "R1/R8", "per-cycle resp_data", 32'(resp_data), 32'(m_resp));
    endtask

    task automatic mbit(bit d, bit oe);
        host_data = d;
        host_oe   = oe;
        mgmt_clk  = 1'b0;
        sys_step();
        sys_step();
        mgmt_clk = 1'b1;
        model_edge(d, oe);
        sys_step();
        sys_step();
    endtask

    task automatic ones(int n);
        repeat (n) mbit(1'b1, 1'b1);
    endtask

    task automatic idle(int n);
        repeat (n) mbit(1'b0, 1'b0);
    endtask

    task automatic header(logic [1:0] st, logic [1:0] op, logic [4:0] phy, logic [4:0] rg);
        for (int i = 1; i >= 0; i--) mbit(st[i], 1'b1);
        for (int i = 1; i >= 0; i--) mbit(op[i], 1'b1);
        for (int i = 4; i >= 0; i--) mbit(phy[i], 1'b1);
        for (int i = 4; i >= 0; i--) mbit(rg[i], 1'b1);
    endtask

    task automatic capture(output logic [15:0] got);
        got = '0;
        for (int i = 0; i < 16; i++) begin
            mbit(1'b0, 1'b0);
            got = {got[14:0], resp_data};
        end
    endtask

    task automatic read_frame(int pre, logic [1:0] st, logic [1:0] op, logic [4:0] phy,
                              logic [4:0] rg, bit drive_ta, output logic [15:0] got);
        ones(pre);
        header(st, op, phy, rg);
        if (drive_ta) begin
            mbit(1'b1, 1'b1);
            mbit(1'b0, 1'b1);
        end else begin
            idle(2);
        end
        capture(got);
        idle(3);
    endtask

    task automatic write_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] rg,
                               logic [1:0] ta, logic [15:0] val, logic [15:0] oe_mask);
        ones(32);
        header(2'b01, op, phy, rg);
        mbit(ta[1], 1'b1);
        mbit(ta[0], 1'b1);
        for (int i = 15; i >= 0; i--) mbit(val[i], oe_mask[i]);
        idle(3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: got %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic        held;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(resp_data === 1'b0, "R9", "resp after reset", 32'(resp_data), 32'h0);
        idle(4);

        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd2, 1'b0, got);
        check(got === 16'h0022, "R9", "reset value entry 2", 32'(got), 32'h0022);
        read_frame(32, 2'b01, 2'b10, 5'd7, 5'd3, 1'b0, got);
        check(got === 16'h161A, "R4", "register address selects entry 3", 32'(got), 32'h161A);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd5, 1'b0, got);
        check(got === 16'h0000, "R9", "cleared entry 5", 32'(got), 32'h0);

        write_frame(2'b01, 5'd0, 5'd5, 2'b10, 16'hBEEF, 16'hFFFF);
        read_frame(32, 2'b01, 2'b10, 5'd31, 5'd5, 1'b0, got);
        check(got === 16'hBEEF, "R5", "write then read back", 32'(got), 32'hBEEF);
        check(got === 16'hBEEF, "R10", "other PHY address answered", 32'(got), 32'hBEEF);

        write_frame(2'b01, 5'd0, 5'd5, 2'b11, 16'h1234, 16'hFFFF);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd5, 1'b0, got);
        check(got === 16'hBEEF, "R5", "bad turnaround write ignored", 32'(got), 32'hBEEF);

        read_frame(32, 2'b01, 2'b10, 5'd1, 5'd3, 1'b1, got);
        check(got === 16'h161A, "R6", "read with driven turnaround 10", 32'(got), 32'h161A);

        write_frame(2'b01, 5'd2, 5'd6, 2'b10, 16'hFFFF, 16'hFF00);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd6, 1'b0, got);
        check(got === 16'hFF00, "R2", "undriven ones stored as zero", 32'(got), 32'hFF00);

        write_frame(2'b01, 5'd0, 5'd7, 2'b10, 16'h8001, 16'hFFFF);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd7, 1'b0, got);
        check(got === 16'h8001, "R6", "MSB-first read of 8001", 32'(got), 32'h8001);

        held = resp_data;
        read_frame(32, 2'b00, 2'b10, 5'd0, 5'd2, 1'b0, got);
        check(got === {16{held}}, "R7", "bad start gives no response", 32'(got), 32'({16{held}}));
        read_frame(32, 2'b01, 2'b11, 5'd0, 5'd2, 1'b0, got);
        check(got === {16{held}}, "R7", "unknown op gives no response", 32'(got), 32'({16{held}}));
        write_frame(2'b00, 5'd0, 5'd7, 2'b10, 16'h0000, 16'hFFFF);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd7, 1'b0, got);
        check(got === 16'h8001, "R7", "unknown op does not write", 32'(got), 32'h8001);
        check(resp_data === 1'b1, "R8", "resp holds after frame", 32'(resp_data), 32'h1);

        idle(8);
        held = resp_data;
        read_frame(31, 2'b01, 2'b10, 5'd0, 5'd2, 1'b0, got);
        check(got === {16{held}}, "R3", "31 ones do not synchronise", 32'(got), 32'({16{held}}));

        idle(4);
        ones(32);
        mbit(1'b0, 1'b1);
        mbit(1'b1, 1'b1);
        mbit(1'b1, 1'b1);
        mbit(1'b0, 1'b1);
        read_frame(32, 2'b01, 2'b10, 5'd0, 5'd2, 1'b0, got);
        check(got === 16'h0022, "R11", "resync in mid-frame", 32'(got), 32'h0022);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule